// File: doc/BRIEF.md
# Toggle-Handshake Write Staging Bridge

This block moves single data words from a slow write clock into an unrelated, much faster clock domain. In the fast domain, the words land in a small FIFO buffer. The buffer is built on a RAM that has separate data-in and data-out paths but only one address. For each word, the writer presents it with a valid strobe. The bridge captures the word in a staging register and flips a request toggle bit. It then holds a busy indication high until the word has been written into the buffer.

The only control signal that crosses domains in the forward direction is the request toggle. In the fast domain, the toggle passes through a synchronizer into a four-state sequencer whose states are Gray coded. The sequencer turns each toggle edge into exactly one single-cycle RAM write at the write pointer. An acknowledge toggle, taken from one state bit of the sequencer, travels back through a synchronizer in the write domain. Busy drops once the acknowledge matches the request.

Reads are requested in the fast domain. Because the RAM address is shared, a write cycle always wins and a read waits. The fast clock must run several times faster than the write clock.

Top module: `tog_stage_bridge`

## Requirements
- R1: After reset, `wr_busy` is 0, `buf_empty` is 1, `buf_full` is 0, and `xfer_strobe` and `rd_valid` are 0.
- R2: A word is accepted on a write-clock edge where `wr_valid` is 1 and `wr_busy` is 0. `wr_busy` is 1 after that edge. A `wr_valid` given while `wr_busy` is 1 is ignored, and that word never reaches the buffer.
- R3: Each accepted word produces exactly one `xfer_strobe` pulse, one fast clock long. Two strobe cycles are never adjacent.
- R4: While the buffer is not full, `wr_busy` returns to 0 within 6 write-clock cycles after the accepting edge.
- R5: Words come out on `rd_data` in the order in which they were accepted.
- R6: While `buf_full` is 1, no `xfer_strobe` occurs and a pending word keeps `wr_busy` at 1. After a read frees a slot, the pending word is written and `wr_busy` drops.
- R7: The write and read pointers wrap at the buffer depth. After more than DEPTH words have passed through, every accepted word has been read back and the buffer reports empty.
- R8: A read is granted on a fast-clock edge where `rd_req` is 1, `buf_empty` is 0 and `xfer_strobe` is 0. `rd_valid` is 1 for exactly the cycle after each grant, with the word on `rd_data`.
- R9: `rd_req` while `buf_empty` is 1 produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Slow write clock |
| wrst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_valid | input | 1 | Writer offers `wr_data` |
| wr_data | input | DW | Word to transfer |
| wr_busy | output | 1 | Transfer pending; new words are refused |
| fclk | input | 1 | Fast buffer clock |
| frst_n | input | 1 | Active-low asynchronous reset, fast domain |
| rd_req | input | 1 | Request to pop one word |
| rd_valid | output | 1 | `rd_data` holds a popped word |
| rd_data | output | DW | Popped word |
| xfer_strobe | output | 1 | RAM write cycle for a staged word |
| buf_empty | output | 1 | Buffer holds no word |
| buf_full | output | 1 | Buffer holds DEPTH words |

## Verification
The first word is written into an idle, empty buffer. This shows the basic toggle-to-strobe path and the busy round trip apart from any contention. The buffer is then filled to the brim and one extra word is offered, which separates correct stalling on full from a dropped or overwritten word. Draining after that crosses the pointer wrap. A mixed phase interleaves random writes, random read requests and refused writes given during busy, so that strobe and read collide on the shared address. It catches lost, duplicated or reordered words that directed cases would miss.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
    // Gray-coded sequencer: one bit changes per step; bit 1 is the acknowledge toggle
    typedef enum logic [1:0] {
        SEQ_IDLE0 = 2'b00,
        SEQ_WRA   = 2'b01,
        SEQ_IDLE1 = 2'b11,
        SEQ_WRB   = 2'b10
    } seq_e;
endpackage

// File: rtl/tsb_sync.sv
module tsb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tsb_wside.sv
module tsb_wside #(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_busy,
    input  logic          ack_tgl,
    output logic          req_tgl,
    output logic [DW-1:0] stage_data
);
    typedef struct packed {
        logic          req;
        logic [DW-1:0] stage;
    } wst_t;

    wst_t d, q;
    logic ack_s;

    tsb_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk(wclk), .rst_n(wrst_n), .d(ack_tgl), .q(ack_s)
    );

    // Busy while the request toggle and the returned acknowledge disagree
    assign wr_busy = q.req ^ ack_s;

    always_comb begin
        d = q;
        if (wr_valid && !wr_busy) begin
            d.req   = ~q.req;
            d.stage = wr_data;
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) q <= '0;
        else         q <= d;
    end

    assign req_tgl    = q.req;
    assign stage_data = q.stage;

    a_r2_busy_after_take: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_valid && !wr_busy) |=> wr_busy);
    a_r2_stage_held: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_busy |=> $stable(q.stage));
endmodule

// File: rtl/tsb_fside.sv
module tsb_fside
    import tsb_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int SYNC  = 2
) (
    input  logic          fclk,
    input  logic          frst_n,
    input  logic          req_tgl,
    input  logic [DW-1:0] stage_data,
    input  logic          rd_req,
    output logic          ack_tgl,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          xfer_strobe,
    output logic          buf_empty,
    output logic          buf_full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        seq_e          st;
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          rv;
        logic [DW-1:0] rdat;
    } fst_t;

    fst_t d, q;
    logic req_s, strobe, grant, full, empty;
    logic [DW-1:0] mem [DEPTH];

    tsb_sync #(.STAGES(SYNC)) u_req_sync (
        .clk(fclk), .rst_n(frst_n), .d(req_tgl), .q(req_s)
    );

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d      = q;
        strobe = (q.st == SEQ_WRA) || (q.st == SEQ_WRB);
        full   = (q.cnt == CW'(DEPTH));
        empty  = (q.cnt == '0);
        grant  = rd_req && !empty && !strobe;
        unique case (q.st)
            SEQ_IDLE0: if (req_s && !full)  d.st = SEQ_WRA;
            SEQ_WRA:                        d.st = SEQ_IDLE1;
            SEQ_IDLE1: if (!req_s && !full) d.st = SEQ_WRB;
            SEQ_WRB:                        d.st = SEQ_IDLE0;
            default:                        d.st = SEQ_IDLE0;
        endcase
        if (strobe) begin
            d.wp  = bump(q.wp);
            d.cnt = q.cnt + CW'(1);
        end
        d.rv = grant;
        if (grant) begin
            d.rp   = bump(q.rp);
            d.cnt  = q.cnt - CW'(1);
            d.rdat = mem[q.rp];
        end
    end

    always_ff @(posedge fclk or negedge frst_n) begin
        if (!frst_n) q <= '{st: SEQ_IDLE0, default: '0};
        else         q <= d;
    end

    always_ff @(posedge fclk) begin
        if (strobe) mem[q.wp] <= stage_data;
    end

    assign ack_tgl     = q.st[1];
    assign xfer_strobe = strobe;
    assign rd_valid    = q.rv;
    assign rd_data     = q.rdat;
    assign buf_empty   = empty;
    assign buf_full    = full;

    a_r3_gray_step: assert property (@(posedge fclk) disable iff (!frst_n)
        $countones(q.st ^ $past(q.st)) <= 1);
    a_r3_single_pulse: assert property (@(posedge fclk) disable iff (!frst_n)
        strobe |=> !strobe);
    a_r6_no_write_full: assert property (@(posedge fclk) disable iff (!frst_n)
        strobe |-> (q.cnt < CW'(DEPTH)));
    a_r8_valid_needs_req: assert property (@(posedge fclk) disable iff (!frst_n)
        q.rv |-> $past(rd_req));
    a_r9_no_pop_empty: assert property (@(posedge fclk) disable iff (!frst_n)
        q.rv |-> ($past(q.cnt) != '0));
endmodule

// File: rtl/tog_stage_bridge.sv
module tog_stage_bridge #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int SYNC  = 2
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_busy,
    input  logic          fclk,
    input  logic          frst_n,
    input  logic          rd_req,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          xfer_strobe,
    output logic          buf_empty,
    output logic          buf_full
);
    logic          req_tgl, ack_tgl;
    logic [DW-1:0] stage_data;

    tsb_wside #(.DW(DW), .SYNC(SYNC)) u_wside (
        .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_busy(wr_busy), .ack_tgl(ack_tgl), .req_tgl(req_tgl),
        .stage_data(stage_data)
    );

    tsb_fside #(.DW(DW), .DEPTH(DEPTH), .SYNC(SYNC)) u_fside (
        .fclk(fclk), .frst_n(frst_n), .req_tgl(req_tgl), .stage_data(stage_data),
        .rd_req(rd_req), .ack_tgl(ack_tgl), .rd_valid(rd_valid), .rd_data(rd_data),
        .xfer_strobe(xfer_strobe), .buf_empty(buf_empty), .buf_full(buf_full)
    );
endmodule

// File: tb/tog_stage_bridge_bench.sv
`timescale 1ns/100ps
module tog_stage_bridge_bench;
    localparam int DW = 8;
    localparam int DEPTH = 8;

    logic wclk = 0, fclk = 0, wrst_n = 0, frst_n = 0;
    logic wr_valid = 0, rd_req = 0;
    logic [DW-1:0] wr_data = '0;
    logic wr_busy, rd_valid, xfer_strobe, buf_empty, buf_full;
    logic [DW-1:0] rd_data;

    int checks = 0, fails = 0;
    int strobe_cnt = 0, wr_idx = 0, rd_idx = 0;
    logic [DW-1:0] exp_mem [256];
    bit prev_strobe = 0, prev_grant = 0, done = 0, writer_done = 0;

    always #2.5  fclk = ~fclk;
    always #18.5 wclk = ~wclk;

    tog_stage_bridge #(.DW(DW), .DEPTH(DEPTH)) u_tog_stage_bridge (
        .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_busy(wr_busy), .fclk(fclk), .frst_n(frst_n), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .xfer_strobe(xfer_strobe),
        .buf_empty(buf_empty), .buf_full(buf_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rand_word();
        return DW'($urandom);
    endfunction

    function automatic bit grant_expected(input bit req, input bit emp, input bit stb);
        return req && !emp && !stb;
    endfunction

    // Fast-domain monitor, sampled at the falling edge
    always @(negedge fclk) begin
        if (frst_n) begin
            if (xfer_strobe) begin
                strobe_cnt++;
                chk(!prev_strobe, "R3 adjacent strobe", 1, 0);
                chk(!buf_full, "R6 strobe while full", 1, 0);
            end
            if (rd_valid || prev_grant)
                chk(rd_valid == prev_grant, "R8 rd_valid timing", rd_valid, prev_grant);
            if (rd_valid) begin
                chk(rd_data == exp_mem[rd_idx % 256], "R5 read order",
                    rd_data, exp_mem[rd_idx % 256]);
                rd_idx++;
            end
            prev_grant  = grant_expected(rd_req, buf_empty, xfer_strobe);
            prev_strobe = xfer_strobe;
        end
    end

    task automatic wr_word(input logic [DW-1:0] v, input bit junk);
        @(posedge wclk); #1;
        while (wr_busy) begin @(posedge wclk); #1; end
        wr_valid = 1; wr_data = v;
        @(posedge wclk); #1;
        wr_valid = 0;
        exp_mem[wr_idx % 256] = v;
        wr_idx++;
        chk(wr_busy == 1, "R2 busy after accept", wr_busy, 1);
        if (junk) begin
            wr_valid = 1; wr_data = ~v;
            @(posedge wclk); #1;
            wr_valid = 0;
        end
    endtask

    task automatic wait_idle(input int bound, input string req);
        int n = 0;
        while (wr_busy && n < 200) begin @(posedge wclk); #1; n++; end
        chk(n <= bound, req, n, bound);
    endtask

    task automatic rd_one();
        @(posedge fclk); #1;
        while (buf_empty || xfer_strobe) begin @(posedge fclk); #1; end
        rd_req = 1;
        @(posedge fclk); #1;
        rd_req = 0;
        @(posedge fclk); #1;
    endtask

    initial begin
        int s0;
        void'($urandom(32'h5eed_0042));
        #1;
        chk(wr_busy == 0 && buf_empty == 1 && buf_full == 0 && xfer_strobe == 0
            && rd_valid == 0, "R1 reset outputs", wr_busy, 0);
        repeat (3) @(posedge wclk);
        #1; wrst_n = 1; frst_n = 1;
        repeat (2) @(posedge wclk); #1;
        chk(wr_busy == 0 && buf_empty == 1 && strobe_cnt == 0, "R1 idle after reset",
            strobe_cnt, 0);

        // single word into an idle buffer
        wr_word(8'hA5, 0);
        wait_idle(6, "R4 busy release");
        chk(strobe_cnt == 1, "R3 one strobe per word", strobe_cnt, 1);
        chk(buf_empty == 0, "R3 word stored", buf_empty, 0);
        rd_one();
        chk(rd_idx == 1, "R8 one read granted", rd_idx, 1);

        // read while empty
        @(posedge fclk); #1; rd_req = 1;
        repeat (6) @(posedge fclk);
        #1; rd_req = 0;
        @(posedge fclk); #1;
        chk(rd_idx == 1, "R9 no pop when empty", rd_idx, 1);

        // fill to the brim, ignored writes mixed in
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(rand_word(), i[0]);
            wait_idle(6, "R4 busy release fill");
        end
        @(negedge fclk);
        chk(buf_full == 1, "R6 full flag", buf_full, 1);
        s0 = strobe_cnt;
        wr_word(8'h3C, 0);
        repeat (20) @(posedge wclk);
        #1;
        chk(wr_busy == 1, "R6 busy held while full", wr_busy, 1);
        chk(strobe_cnt == s0, "R6 no strobe while full", strobe_cnt, s0);
        rd_one();
        wait_idle(8, "R6 pending word lands");
        chk(strobe_cnt == s0 + 1, "R6 stalled word written", strobe_cnt, s0 + 1);
        while (!buf_empty) rd_one();
        repeat (4) @(posedge fclk);
        chk(rd_idx == wr_idx, "R7 wrap drain count", rd_idx, wr_idx);
        chk(buf_empty == 1, "R7 empty after wrap", buf_empty, 1);

        // mixed random traffic
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    wr_word(rand_word(), ($urandom % 3) == 0);
                    repeat ($urandom % 3) @(posedge wclk);
                end
                writer_done = 1;
            end
            begin
                while (!(writer_done && !wr_busy && buf_empty && rd_idx == wr_idx)) begin
                    @(posedge fclk); #1;
                    rd_req = (($urandom % 4) != 0);
                end
                rd_req = 0;
            end
        join
        repeat (4) @(posedge fclk);
        chk(rd_idx == wr_idx, "R5 all words returned", rd_idx, wr_idx);
        chk(strobe_cnt == wr_idx, "R3 strobes equal accepted words", strobe_cnt, wr_idx);
        chk(buf_empty == 1 && buf_full == 0, "R7 pointers settle empty", buf_empty, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge fclk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule